// File: doc/BRIEF.md
# Two-Way Set-Associative Unified Cache

This block is a single-level cache that keeps both instructions and data for a simple processor, with 8 KB of storage. It sits between a CPU request port and a word-addressed main-memory port. The CPU request port carries a byte address, read and write strobes, write data, read data and a stall. The memory port uses a request/ready handshake. Each set has two ways. Both stored tags are compared with the request at the same time, so two lines that share a set index can be resident together. This removes the conflict misses that a direct-mapped array of the same size would take.

Every write is forwarded to main memory, so memory always holds the current copy and lines never become dirty. A write that misses first brings the line in, and then the written word is merged into it. A read that misses fetches the whole eight-word line, installs it, and then returns the word. Two free-running counters report the number of references and the number of hits, so the hit ratio can be measured on a workload.

Top module: `cache2w_top`

## Requirements
- R1: A byte address is decoded as follows. Bits [1:0] are ignored. Bits [4:2] select the word in the line, bits [11:5] select one of 128 sets, and bits [31:12] are the tag. The memory word address is the byte address shifted right by two.
- R2: Two lines with the same set index and different tags can be resident at the same time, and both then hit.
- R3: When a read hits, cpu_stall stays low in the cycle the request is presented. cpu_rdata carries the addressed word in that cycle, and there is no memory traffic.
- R4: When a read misses, the cache reads the eight words of the line from memory, starting at word 0 and going up one word at a time. It installs the line and then returns the addressed word. cpu_stall stays high until the last beat has been accepted and drops in the following cycle.
- R5: Every write, whether it hits or misses, issues exactly one memory write with mem_we high, at the word address and with the write data. cpu_stall stays high until memory has accepted that write.
- R6: When a write misses, the line is fetched before the write goes to memory. Afterwards, reads of any word in that line hit, and the written word returns the new data.
- R7: On a miss, an invalid way is filled if there is one. Otherwise the least-recently-used way is replaced. Every hit and every fill makes its way the most recently used in the set.
- R8: access_count goes up by one for each request accepted from idle. hit_count goes up by one for each such request that hits.
- R9: Reset is synchronous and active high. It invalidates every line, zeroes both counters and leaves cpu_stall low. After reset, any access misses.
- R10: All 256 lines (128 sets of two ways) can be resident at once, and all of them hit afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | CPU byte address, held stable while stalled |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when cpu_stall is low |
| cpu_stall | output | 1 | Request not yet complete |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory has accepted or answered the request |
| hit_count | output | 32 | Number of hits |
| access_count | output | 32 | Number of references |

## Verification
The bench goes after the replacement order by walking three tags through one set. A design with an inverted or stale recency bit would evict the wrong line, and the bench would see fill traffic where it expects none. It times stalls exactly: 0, 2, 16 or 18 cycles for a read hit, a write hit, a read miss and a write miss. A missing write-through or write-allocate, or a fill that finishes one beat early, changes these counts or leaves memory unchanged. It also checks the fill word order, every word returned against a memory model, occupancy of all 256 lines, and invalidation after reset.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_RESUME
    } cache_state_e;

    typedef struct packed {
        logic hit;
        logic hit_way;
        logic victim_way;
    } lookup_t;

    // invalid way first, way 0 before way 1, otherwise the LRU way
    function automatic logic choose_victim(input logic v0, input logic v1, input logic lru);
        if (!v0) return 1'b0;
        if (!v1) return 1'b1;
        return lru;
    endfunction

endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
    import cache2w_pkg::*;
#(
    parameter int TAG_W = 20,
    parameter int SETS  = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             install_en,
    input  logic             install_way,
    output lookup_t          look
);

    logic [1:0]      hit_w;
    logic [1:0]      valid_at;
    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  valid_q;
        logic             sel;

        assign sel = install_en && (install_way == 1'(w));

        always_ff @(posedge clk) begin
            if (sel) tag_mem[idx] <= tag;
        end

        always_ff @(posedge clk) begin
            if (rst) valid_q <= '0;
            else if (sel) valid_q[idx] <= 1'b1;
        end

        assign valid_at[w] = valid_q[idx];
        assign hit_w[w]    = valid_q[idx] && (tag_mem[idx] == tag);
    end

    always_ff @(posedge clk) begin
        if (rst) lru_q <= '0;
        else if (install_en) lru_q[idx] <= ~install_way;
        else if (touch_en) lru_q[idx] <= ~touch_way;
    end

    always_comb begin
        look.hit        = |hit_w;
        look.hit_way    = hit_w[1];
        look.victim_way = choose_victim(valid_at[0], valid_at[1], lru_q[idx]);
    end

    AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
        !(hit_w[0] && hit_w[1])); // R2

    AST_INSTALL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        install_en |-> !look.hit); // R7

endmodule

// File: rtl/cache2w_data.sv
module cache2w_data #(
    parameter int DATA_W     = 32,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  we,
    input  logic                  wway,
    input  logic [OFF_W-1:0]      woff,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [OFF_W-1:0]      roff,
    output logic [1:0][DATA_W-1:0] rword
);

    localparam int DEPTH = SETS * LINE_WORDS;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wway == 1'(w))) mem[{idx, woff}] <= wdata;
        end

        assign rword[w] = mem[{idx, roff}];
    end

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  lookup_t          look,
    input  logic             mem_ready,
    output logic             cpu_stall,
    output logic             mem_req,
    output logic             mem_we,
    output logic             fill_phase,
    output logic             fill_we,
    output logic             fill_way,
    output logic [OFF_W-1:0] beat,
    output logic             install_en,
    output logic             touch_en,
    output logic             touch_way,
    output logic             word_we,
    output logic             acc_inc,
    output logic             hit_inc
);

    localparam logic [OFF_W-1:0] LAST_BEAT = {OFF_W{1'b1}};

    cache_state_e     state_q, state_d;
    logic [OFF_W-1:0] beat_q;
    logic             victim_q;
    logic             req;

    assign req       = cpu_rd | cpu_wr;
    assign beat      = beat_q;
    assign fill_way  = victim_q;
    assign touch_way = look.hit_way;

    always_comb begin
        state_d    = state_q;
        cpu_stall  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        fill_phase = 1'b0;
        fill_we    = 1'b0;
        install_en = 1'b0;
        touch_en   = 1'b0;
        word_we    = 1'b0;
        acc_inc    = 1'b0;
        hit_inc    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    acc_inc = 1'b1;
                    if (look.hit) begin
                        hit_inc  = 1'b1;
                        touch_en = 1'b1;
                        if (cpu_wr) begin
                            cpu_stall = 1'b1;
                            state_d   = ST_WRITE;
                        end
                    end else begin
                        cpu_stall = 1'b1;
                        state_d   = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                cpu_stall  = 1'b1;
                mem_req    = 1'b1;
                fill_phase = 1'b1;
                if (mem_ready) begin
                    fill_we = 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        install_en = 1'b1;
                        state_d    = cpu_wr ? ST_WRITE : ST_RESUME;
                    end
                end
            end
            ST_WRITE: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                word_we   = 1'b1;
                if (mem_ready) state_d = ST_RESUME;
            end
            ST_RESUME: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            victim_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                beat_q   <= '0;
                victim_q <= look.victim_way;
            end else if (fill_we) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    AST_RESUME_SEES_LINE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESUME) |-> look.hit); // R4

    AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (rst)
        (fill_phase && mem_ready && beat_q == LAST_BEAT) |=> look.hit); // R4

    AST_READ_FILL_STALLS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> cpu_stall); // R4

    AST_WRITE_TO_RESIDENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |-> look.hit); // R6

    AST_WRITE_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_wr) |=> mem_req); // R5

endmodule

// File: rtl/cache2w_stats.sv
module cache2w_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_inc,
    input  logic             hit_inc,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] hit_cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt <= '0;
            hit_cnt <= '0;
        end else begin
            if (acc_inc) acc_cnt <= acc_cnt + 1'b1;
            if (hit_inc) hit_cnt <= hit_cnt + 1'b1;
        end
    end

    AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        hit_cnt <= acc_cnt); // R8

    AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc_cnt == $past(acc_cnt)) || (acc_cnt == $past(acc_cnt) + 1'b1)); // R8

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 128,
    parameter int CNT_W      = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 cpu_addr,
    input  logic                              cpu_rd,
    input  logic                              cpu_wr,
    input  logic [DATA_W-1:0]                 cpu_wdata,
    output logic [DATA_W-1:0]                 cpu_rdata,
    output logic                              cpu_stall,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W-1:0]                 mem_wdata,
    input  logic [DATA_W-1:0]                 mem_rdata,
    input  logic                              mem_ready,
    output logic [CNT_W-1:0]                  hit_count,
    output logic [CNT_W-1:0]                  access_count
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - BYTE_W - OFF_W - IDX_W;

    logic [OFF_W-1:0]        cpu_off;
    logic [IDX_W-1:0]        cpu_idx;
    logic [TAG_W-1:0]        cpu_tag;
    lookup_t                 look;
    logic                    fill_phase, fill_we, fill_way;
    logic [OFF_W-1:0]        beat;
    logic                    install_en, touch_en, touch_way, word_we;
    logic                    acc_inc, hit_inc;
    logic                    arr_we, arr_way;
    logic [OFF_W-1:0]        arr_off;
    logic [DATA_W-1:0]       arr_wdata;
    logic [1:0][DATA_W-1:0]  rword;

    assign cpu_off = cpu_addr[BYTE_W +: OFF_W];
    assign cpu_idx = cpu_addr[BYTE_W + OFF_W +: IDX_W];
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    cache2w_tags #(.TAG_W(TAG_W), .SETS(SETS)) tags_i (
        .clk         (clk),
        .rst         (rst),
        .idx         (cpu_idx),
        .tag         (cpu_tag),
        .touch_en    (touch_en),
        .touch_way   (touch_way),
        .install_en  (install_en),
        .install_way (fill_way),
        .look        (look)
    );

    cache2w_ctrl #(.OFF_W(OFF_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .look       (look),
        .mem_ready  (mem_ready),
        .cpu_stall  (cpu_stall),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .fill_phase (fill_phase),
        .fill_we    (fill_we),
        .fill_way   (fill_way),
        .beat       (beat),
        .install_en (install_en),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .word_we    (word_we),
        .acc_inc    (acc_inc),
        .hit_inc    (hit_inc)
    );

    assign arr_we    = fill_we | word_we;
    assign arr_way   = fill_we ? fill_way : look.hit_way;
    assign arr_off   = fill_we ? beat : cpu_off;
    assign arr_wdata = fill_we ? mem_rdata : cpu_wdata;

    cache2w_data #(.DATA_W(DATA_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) data_i (
        .clk   (clk),
        .idx   (cpu_idx),
        .we    (arr_we),
        .wway  (arr_way),
        .woff  (arr_off),
        .wdata (arr_wdata),
        .roff  (cpu_off),
        .rword (rword)
    );

    cache2w_stats #(.CNT_W(CNT_W)) stats_i (
        .clk     (clk),
        .rst     (rst),
        .acc_inc (acc_inc),
        .hit_inc (hit_inc),
        .acc_cnt (access_count),
        .hit_cnt (hit_count)
    );

    assign cpu_rdata = rword[look.hit_way];
    assign mem_wdata = cpu_wdata;
    assign mem_addr  = fill_phase ? {cpu_tag, cpu_idx, beat} : cpu_addr[ADDR_W-1:BYTE_W];

endmodule

// File: tb/cache2w_top_tb_top.sv
module cache2w_top_tb_top;

    localparam int MEMW = 16384;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready;
    logic [31:0] hit_count, access_count;

    int errors = 0;
    int checks = 0;
    int exp_acc = 0;
    int exp_hit = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    int order_err = 0;
    logic [29:0] fill_next = '0;
    logic [31:0] mem_model [MEMW];

    always #2 clk = ~clk;

    cache2w_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_stall    (cpu_stall),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ready    (mem_ready),
        .hit_count    (hit_count),
        .access_count (access_count)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory: one idle cycle, then a one-cycle ready pulse per beat
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < MEMW; i++) mem_model[i] = (i * 32'h9E3779B1) ^ 32'hA5C30000;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_req === 1'b1) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem_model[mem_addr[13:0]] = mem_wdata;
                    wr_beats++;
                end else begin
                    if (rd_beats % 8 == 0) begin
                        if (mem_addr[2:0] != 3'd0) order_err++;
                    end else if (mem_addr != fill_next) begin
                        order_err++;
                    end
                    fill_next = mem_addr + 1'b1;
                    mem_rdata = mem_model[mem_addr[13:0]];
                    rd_beats++;
                end
            end
        end
    end

    task automatic access(input logic [31:0] addr, input bit wr, input logic [31:0] wd,
                          input bit hit, input string req);
        int rb0 = rd_beats;
        int wb0 = wr_beats;
        int stalls = 0;
        int exp_stalls;
        logic [31:0] got;
        @(negedge clk);
        cpu_addr  = addr;
        cpu_rd    = !wr;
        cpu_wr    = wr;
        cpu_wdata = wd;
        #1;
        while (cpu_stall && stalls < 2000) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        got = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        exp_acc++;
        if (hit) exp_hit++;
        exp_stalls = wr ? (hit ? 2 : 18) : (hit ? 0 : 16);
        check_eq(req, $sformatf("fill beats @%0h", addr), rd_beats - rb0, hit ? 0 : 8);
        check_eq(req, $sformatf("stall cycles @%0h", addr), stalls, exp_stalls);
        if (wr) begin
            check_eq("R5", $sformatf("memory writes @%0h", addr), wr_beats - wb0, 1);
            check_eq("R5", $sformatf("memory word @%0h", addr), mem_model[addr[15:2]], wd);
        end else begin
            check_eq(req, $sformatf("read data @%0h", addr), got, mem_model[addr[15:2]]);
        end
    endtask

    task automatic check_counts(input string req);
        check_eq(req, "access_count", access_count, exp_acc);
        check_eq(req, "hit_count", hit_count, exp_hit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cpu_addr = '0;
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        check_eq("R9", "stall after reset", cpu_stall, 0);
        check_eq("R9", "mem_req after reset", mem_req, 0);
        check_counts("R9");

        // R4 then R3, R1: cold line, then every word of it and a misaligned byte address
        access(32'h0000_0060, 0, 0, 0, "R4");
        for (int w = 1; w < 8; w++) access(32'h0000_0060 + w * 4, 0, 0, 1, "R3");
        access(32'h0000_0063, 0, 0, 1, "R1");

        // R2: second tag in the same set
        access(32'h0000_1060, 0, 0, 0, "R2");
        access(32'h0000_0060, 0, 0, 1, "R2");
        access(32'h0000_1060, 0, 0, 1, "R2");

        // R7: LRU walk in set 3 with tags 0, 1, 2
        access(32'h0000_0064, 0, 0, 1, "R7");
        access(32'h0000_2060, 0, 0, 0, "R7");
        access(32'h0000_1060, 0, 0, 0, "R7");
        access(32'h0000_2060, 0, 0, 1, "R7");
        access(32'h0000_0060, 0, 0, 0, "R7");
        access(32'h0000_2060, 0, 0, 1, "R7");
        check_counts("R8");

        // R5: write hit, then read back
        access(32'h0000_2068, 1, 32'hCAFE_0001, 1, "R5");
        access(32'h0000_2068, 0, 0, 1, "R5");

        // R6: write miss allocates
        access(32'h0000_5128, 1, 32'hBEEF_0002, 0, "R6");
        access(32'h0000_5128, 0, 0, 1, "R6");
        access(32'h0000_5120, 0, 0, 1, "R6");

        // R7: both invalid ways used before any replacement
        access(32'h0000_3280, 0, 0, 0, "R7");
        access(32'h0000_4280, 0, 0, 0, "R7");
        access(32'h0000_3280, 0, 0, 1, "R7");
        access(32'h0000_4280, 0, 0, 1, "R7");
        check_counts("R8");

        // R10: fill every line of the array, then hit all of them
        for (int s = 0; s < 128; s++)
            for (int t = 6; t < 8; t++)
                access(t * 32'h1000 + s * 32 + (s % 8) * 4, 0, 0, 0, "R10");
        for (int s = 0; s < 128; s++)
            for (int t = 6; t < 8; t++)
                access(t * 32'h1000 + s * 32 + ((s + t) % 8) * 4, 0, 0, 1, "R10");
        check_counts("R8");
        check_eq("R4", "fill order errors", order_err, 0);

        // R9: reset invalidates resident lines and clears counters
        access(32'h0000_60A0, 0, 0, 1, "R9");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_acc = 0;
        exp_hit = 0;
        #1;
        check_counts("R9");
        access(32'h0000_60A0, 0, 0, 0, "R9");
        check_counts("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule